// File: doc/BRIEF.md
# Framed Serial Transmitter with Sync-Error Detection

This block is the transmit half of a synchronous, frame-based serial port. Software places a word in a holding register. A frame-sync pulse then copies that word into a shift register and sends it on a single data line, most significant bit first, one bit per transmit clock. The block runs entirely on the transmit clock, and the frame-sync pulse is sampled on that same clock. The pulse can come from an external pin or from an internal rate source, and a select input chooses between them.

A frame-sync pulse can arrive while a word is still being shifted. When this happens, the block treats the pulse as unexpected. It latches a sticky error bit and restarts the frame from the top. If no fresh word is waiting, the same word is sent again. An ignore mode discards such pulses instead, and the current frame continues.

A two-bit mode input selects the interrupt source. In one mode the interrupt pulses on the error bit. In another it pulses when the holding register empties.

Top module: `framed_tx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `dout` is 0, `ready` is 1, `sync_err` is 0 and `tx_int` is 0, and no frame is in progress.
- R2: A cycle with `wr_en` high stores `wr_data` in the holding register, and `ready` reads 0 after that clock edge.
- R3: A selected frame-sync pulse seen while no frame is active, or while the last bit is on `dout`, starts a frame. After that edge `dout` carries bit W-1, and each following clock moves one bit lower down to bit 0. The held word is copied and `ready` returns to 1. If nothing was written since the last copy, the previously sent word is sent again. No error is raised.
- R4: With `ignore_fs` low, a selected frame-sync pulse seen while a frame still has bits to send sets `sync_err` after that edge. The frame restarts at bit W-1, using the held word if one is waiting and the current word otherwise.
- R5: With `ignore_fs` high, a mid-frame pulse is discarded. The next bit of the current word follows, and `sync_err` is unchanged.
- R6: `sync_err` stays set until reset or a cycle with `err_wr` high and `err_wdata` 0. A cycle with `err_wr` high and `err_wdata` 1 leaves it unchanged. If a clear and an unexpected pulse fall in the same cycle, the bit ends up set.
- R7: With `int_mode` = 2'b11, `tx_int` is high for exactly the one cycle in which `sync_err` first reads 1.
- R8: With `int_mode` = 2'b00, `tx_int` is high for exactly the one cycle in which `ready` first reads 1 again after a copy.
- R9: With `fs_sel` = 0 only `fs_ext` acts as frame sync. With `fs_sel` = 1 only `fs_int` acts as frame sync, and pulses on the other input start nothing.
- R10: Between frames, `dout` holds the last bit it drove.
- R11: Driving `rst_n` low during a frame aborts the frame and clears `sync_err` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low transmitter reset |
| fs_ext | input | 1 | Frame sync from the external pin |
| fs_int | input | 1 | Frame sync from the internal rate source |
| fs_sel | input | 1 | Frame sync source: 0 external, 1 internal |
| ignore_fs | input | 1 | 1 discards mid-frame sync pulses |
| int_mode | input | 2 | Interrupt source: 00 ready, 11 sync error, others none |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | W | Word to transmit |
| err_wr | input | 1 | Write strobe for the error bit |
| err_wdata | input | 1 | Value written to the error bit (only 0 acts) |
| dout | output | 1 | Serial data, MSB first |
| ready | output | 1 | Holding register free for a new word |
| sync_err | output | 1 | Sticky unexpected frame-sync flag |
| tx_int | output | 1 | One-cycle transmit interrupt pulse |

## Verification
Two functions can fall in the same cycle here: a software clear of the error bit, and a new unexpected pulse that sets it. The stimulus table drives a mid-frame pulse in the same cycle as an error-bit write of 0. The result is judged on the outputs after that edge: `sync_err` must be 1, `tx_int` must pulse, and `dout` must show the restarted word's top bit. A second coincidence is also covered: a restart with no new write must resend the same word bit by bit, and `ready` must stay high throughout.

// File: rtl/framed_tx_pkg.sv
package framed_tx_pkg;

    // Interrupt source selection; only two codes raise the interrupt.
    typedef enum logic [1:0] {
        IRQ_ON_READY   = 2'b00,
        IRQ_NONE_A     = 2'b01,
        IRQ_NONE_B     = 2'b10,
        IRQ_ON_SYNCERR = 2'b11
    } irq_mode_e;

endpackage

// File: rtl/ftx_fs_select.sv
module ftx_fs_select #(
    parameter int NSRC = 2
) (
    input  logic [NSRC-1:0]                         src,
    input  logic [((NSRC > 1) ? $clog2(NSRC) : 1)-1:0] sel,
    output logic                                    fs
);

    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

    // Pick one frame-sync source; every source is treated identically.
    always_comb begin
        fs = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SW'(i)) fs = src[i];
        end
    end

endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs,
    input  logic         ignore_fs,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         dout,
    output logic         ready,
    output logic         frame_busy,
    output logic         unexpected,
    output logic         ready_rise
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  hold;   // holding register
        logic          full;   // holding register occupied
        logic [W-1:0]  last;   // word of the current / most recent frame
        logic [W-1:0]  sreg;   // bits still to send, left aligned
        logic [CW-1:0] rem;    // bits remaining after the one on dout
        logic          dout;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic          busy;
    logic          start;
    logic [W-1:0]  word;

    always_comb begin
        s_d   = s_q;
        busy  = (s_q.rem != '0);
        // A pulse during a frame is either a restart or discarded.
        start = fs && (!busy || !ignore_fs);
        word  = s_q.full ? s_q.hold : s_q.last;

        if (start) begin
            s_d.last = word;
            s_d.sreg = word << 1;
            s_d.dout = word[W-1];
            s_d.rem  = CW'(W - 1);
            s_d.full = 1'b0;
        end else if (busy) begin
            s_d.dout = s_q.sreg[W-1];
            s_d.sreg = s_q.sreg << 1;
            s_d.rem  = s_q.rem - CW'(1);
        end

        // A write in the copy cycle lands after the copy.
        if (wr_en) begin
            s_d.hold = wr_data;
            s_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout       = s_q.dout;
    assign ready      = !s_q.full;
    assign frame_busy = busy;
    assign unexpected = fs && busy && !ignore_fs;
    assign ready_rise = s_q.full && !s_d.full;

endmodule

// File: rtl/ftx_err_irq.sv
module ftx_err_irq
    import framed_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unexpected,
    input  logic       ready_rise,
    input  logic       err_wr,
    input  logic       err_wdata,
    input  logic [1:0] int_mode,
    output logic       sync_err,
    output logic       tx_int
);

    typedef struct packed {
        logic err;
        logic irq;
    } err_st_t;

    err_st_t   e_d, e_q;
    irq_mode_e mode;

    always_comb begin
        e_d  = e_q;
        mode = irq_mode_e'(int_mode);

        // Setting beats a same-cycle software clear; writing 1 does nothing.
        if (unexpected)                 e_d.err = 1'b1;
        else if (err_wr && !err_wdata)  e_d.err = 1'b0;

        case (mode)
            IRQ_ON_SYNCERR: e_d.irq = e_d.err && !e_q.err;
            IRQ_ON_READY:   e_d.irq = ready_rise;
            default:        e_d.irq = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign sync_err = e_q.err;
    assign tx_int   = e_q.irq;

endmodule

// File: rtl/framed_tx.sv
module framed_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs_ext,
    input  logic         fs_int,
    input  logic         fs_sel,
    input  logic         ignore_fs,
    input  logic [1:0]   int_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         err_wr,
    input  logic         err_wdata,
    output logic         dout,
    output logic         ready,
    output logic         sync_err,
    output logic         tx_int
);

    localparam int NSRC = 2;

    logic fs;
    logic unexpected;
    logic frame_busy;
    logic ready_rise;

    ftx_fs_select #(.NSRC(NSRC)) u_fsel (
        .src ({fs_int, fs_ext}),
        .sel (fs_sel),
        .fs  (fs)
    );

    ftx_shifter #(.W(W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs         (fs),
        .ignore_fs  (ignore_fs),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .dout       (dout),
        .ready      (ready),
        .frame_busy (frame_busy),
        .unexpected (unexpected),
        .ready_rise (ready_rise)
    );

    ftx_err_irq u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .unexpected (unexpected),
        .ready_rise (ready_rise),
        .err_wr     (err_wr),
        .err_wdata  (err_wdata),
        .int_mode   (int_mode),
        .sync_err   (sync_err),
        .tx_int     (tx_int)
    );

endmodule

// File: rtl/framed_tx_chk.sv
module framed_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fs,
    input logic       ignore_fs,
    input logic [1:0] int_mode,
    input logic       wr_en,
    input logic       err_wr,
    input logic       err_wdata,
    input logic       ready,
    input logic       sync_err,
    input logic       tx_int,
    input logic       unexpected,
    input logic       frame_busy
);

    // R4
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unexpected |=> sync_err);

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !(err_wr && !err_wdata)) |=> sync_err);

    // R4
    sync_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> $past(unexpected));

    // R7
    irq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_err) && $past(int_mode) == 2'b11) |-> tx_int);

    // R8
    irq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && $past(int_mode) == 2'b00) |-> tx_int);

    // R5
    ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ignore_fs && fs && frame_busy && !sync_err) |=> !sync_err);

    // R2
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(wr_en));

endmodule

bind framed_tx framed_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs         (fs),
    .ignore_fs  (ignore_fs),
    .int_mode   (int_mode),
    .wr_en      (wr_en),
    .err_wr     (err_wr),
    .err_wdata  (err_wdata),
    .ready      (ready),
    .sync_err   (sync_err),
    .tx_int     (tx_int),
    .unexpected (unexpected),
    .frame_busy (frame_busy)
);

// File: tb/sim_framed_tx.sv
`timescale 1ns/1ps
module sim_framed_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs_ext = 1'b0, fs_int = 1'b0, fs_sel = 1'b0, ignore_fs = 1'b0;
    logic [1:0] int_mode = 2'b11;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       err_wr = 1'b0, err_wdata = 1'b0;
    logic       dout, ready, sync_err, tx_int;

    int applied = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    framed_tx #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .fs_ext(fs_ext), .fs_int(fs_int),
        .fs_sel(fs_sel), .ignore_fs(ignore_fs), .int_mode(int_mode),
        .wr_en(wr_en), .wr_data(wr_data), .err_wr(err_wr),
        .err_wdata(err_wdata), .dout(dout), .ready(ready),
        .sync_err(sync_err), .tx_int(tx_int)
    );

    // Vector: req[18:15] fs[14] wr[13] data[12:5] clr[4] | dout ready err int
    localparam logic [18:0] VEC [0:17] = '{
        {4'd2,  1'b0, 1'b1, 8'hA5, 1'b0, 4'b0000}, // R2 write A5
        {4'd3,  1'b1, 1'b0, 8'h00, 1'b0, 4'b1100}, // R3 start, bit7
        {4'd3,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0100}, // R3 bit6
        {4'd3,  1'b0, 1'b0, 8'h00, 1'b0, 4'b1100}, // R3 bit5
        {4'd3,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0100}, // R3 bit4
        {4'd4,  1'b1, 1'b0, 8'h00, 1'b0, 4'b1111}, // R4 mid pulse, restart
        {4'd7,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0110}, // R7 pulse is one cycle
        {4'd6,  1'b0, 1'b0, 8'h00, 1'b1, 4'b1100}, // R6 clear
        {4'd6,  1'b1, 1'b0, 8'h00, 1'b1, 4'b1111}, // R6 set beats clear
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0110}, // R4 same word bit6
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b1110},
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0110},
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0110},
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b1110},
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b0110},
        {4'd4,  1'b0, 1'b0, 8'h00, 1'b0, 4'b1110}, // bit0
        {4'd10, 1'b0, 1'b1, 8'h3C, 1'b1, 4'b1000}, // R10 dout holds 1
        {4'd3,  1'b1, 1'b0, 8'h00, 1'b0, 4'b0100}  // R3 idle start 3C
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        // R1 reset state
        check("R1 dout", dout, 1'b0);
        check("R1 ready", ready, 1'b1);
        check("R1 sync_err", sync_err, 1'b0);
        check("R1 tx_int", tx_int, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 18; i++) begin
            fs_ext    = VEC[i][14];
            wr_en     = VEC[i][13];
            wr_data   = VEC[i][12:5];
            err_wr    = VEC[i][4];
            err_wdata = 1'b0;
            tick();
            check($sformatf("R%0d vec%0d dout", VEC[i][18:15], i), dout, VEC[i][3]);
            check($sformatf("R%0d vec%0d ready", VEC[i][18:15], i), ready, VEC[i][2]);
            check($sformatf("R%0d vec%0d sync_err", VEC[i][18:15], i), sync_err, VEC[i][1]);
            check($sformatf("R%0d vec%0d tx_int", VEC[i][18:15], i), tx_int, VEC[i][0]);
        end
        fs_ext = 1'b0; wr_en = 1'b0; err_wr = 1'b0;

        // R5 ignore mode: C3 = 1100_0011
        do_reset();
        ignore_fs = 1'b1;
        wr_en = 1'b1; wr_data = 8'hC3; tick(); wr_en = 1'b0;
        fs_ext = 1'b1; tick(); fs_ext = 1'b0;
        check("R3 first bit", dout, 1'b1);
        tick();
        tick();
        fs_ext = 1'b1; tick(); fs_ext = 1'b0;
        check("R5 frame continues", dout, 1'b0);
        check("R5 no error", sync_err, 1'b0);

        // R4 / R7 restart from this frame, then R6 write of 1
        ignore_fs = 1'b0;
        fs_ext = 1'b1; tick(); fs_ext = 1'b0;
        check("R4 restart msb", dout, 1'b1);
        check("R4 error set", sync_err, 1'b1);
        check("R7 irq on error", tx_int, 1'b1);
        err_wr = 1'b1; err_wdata = 1'b1; tick(); err_wr = 1'b0;
        check("R6 write one ignored", sync_err, 1'b1);
        check("R7 irq single cycle", tx_int, 1'b0);

        // R11 reset mid-frame
        rst_n = 1'b0;
        #1;
        check("R11 error cleared", sync_err, 1'b0);
        check("R11 dout", dout, 1'b0);
        check("R11 ready", ready, 1'b1);
        tick();
        rst_n = 1'b1;

        // R8 interrupt on ready
        int_mode = 2'b00;
        wr_en = 1'b1; wr_data = 8'h81; tick(); wr_en = 1'b0;
        check("R2 ready low", ready, 1'b0);
        check("R8 no irq on write", tx_int, 1'b0);
        fs_ext = 1'b1; tick(); fs_ext = 1'b0;
        check("R8 ready back", ready, 1'b1);
        check("R8 irq on ready", tx_int, 1'b1);
        tick();
        check("R8 irq single cycle", tx_int, 1'b0);
        check("R3 bit6 of 81", dout, 1'b0);

        // R9 source select
        do_reset();
        fs_sel = 1'b1;
        wr_en = 1'b1; wr_data = 8'hAA; tick(); wr_en = 1'b0;
        fs_ext = 1'b1; tick(); fs_ext = 1'b0;
        check("R9 external ignored", ready, 1'b0);
        fs_int = 1'b1; tick(); fs_int = 1'b0;
        check("R9 internal starts", ready, 1'b1);
        check("R9 msb", dout, 1'b1);
        repeat (7) tick();
        check("R3 last bit", dout, 1'b0);
        tick();
        tick();
        check("R10 idle hold", dout, 1'b0);

        // R3 idle pulse resends last word
        fs_int = 1'b1; tick(); fs_int = 1'b0;
        check("R3 resend msb", dout, 1'b1);
        check("R3 resend no error", sync_err, 1'b0);
        tick();
        check("R3 resend bit6", dout, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end

endmodule